// File: doc/BRIEF.md
# Banked Level Interrupt Controller with Vector Readout

This block collects 96 level-sensitive interrupt requests, arranged as three banks of 32, and turns them into one interrupt line for a processor. Every source that is high on a clock edge sets its pending bit. Software enables sources bank by bank and can also mask them. A source is active when it is pending, enabled and not masked. Active sources drive the processor interrupt.

A vector register gives the number of the lowest active source, so a handler can read it, service that source, acknowledge it and read again until the vector reads zero. Pending bits are acknowledged by writing ones. A source whose input stays high sets its bit again right after the acknowledge. A fast-path view shows pending, enabled sources whose mask bit is set. A protection flag and an NMI control field are kept as plain read/write storage.

Access is through a simple 32-bit register bus with separate read and write strobes and a byte address. Read data comes back one cycle after the read strobe, marked by a valid flag. A two-state response machine handles this. Its states are RSP_IDLE, where no data is presented, and RSP_SEND, where the captured word is driven for one cycle. The machine moves from RSP_IDLE to RSP_SEND on a read strobe and stays in RSP_SEND while reads arrive back to back. With no read strobe, either state moves to RSP_IDLE.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, all pending, enable and mask bits, the protection flag and the NMI field are zero, `irq_out` is low and every register reads zero.
- R2: Source k sets bit k%32 of the pending word of bank k/32 on every edge where its input is high. The pending word of bank n is at offset 0x10+4n.
- R3: Writing a pending word clears the bits written as one and keeps the bits written as zero. A source that is still high after the clear reads back as set again.
- R4: `irq_out` is a register. It is high in the cycle after some source is pending, enabled (bit set at 0x40+4n) and not masked (bit clear at 0x50+4n), and low otherwise.
- R5: The word at offset 0x00 holds, in bits [8:2], the number of the lowest-numbered active source among sources 1 to 95. Every other bit is zero, and the whole word is zero when no such source exists. Source 0 never shows in the vector, but it still drives `irq_out`.
- R6: The word at 0x20+4n reads pending AND enable AND mask for bank n. Writes to it are ignored.
- R7: The enable words at 0x40+4n and the mask words at 0x50+4n store all 32 written bits and read them back.
- R8: The protection flag (offset 0x08, bit 0) and the NMI field (offset 0x0C, bits [1:0]) store and return written values. Their other bits read zero.
- R9: Offsets that are not word aligned, and aligned offsets outside the map (for example 0x04, 0x1C, 0x60), read zero, and writes to them change no register.
- R10: `bus_rvalid` is high in exactly the cycles that follow a cycle with `bus_rd` high. `bus_rdata` then carries the register value at the time of the request, and it is zero when `bus_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 96 | Level interrupt request inputs, source k at bit k |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read response valid, one cycle after `bus_rd` |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The hardest case to reach from the ports is an acknowledge that lands while the source is still high. In that case the clear and the new set hit the same edge, and the set must win. A second hard case is a vector read that has to skip a lower source which is pending but masked or disabled. Directed sequences build both cases on purpose: they hold a source high across a one-to-clear write, and they enable two sources in different banks and then mask the lower one. Long runs of seeded random traffic then toggle source levels one bit at a time while enable, mask and acknowledge writes go on, so the lowest active source keeps moving between banks.

// File: rtl/bic_pkg.sv
package bic_pkg;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_VEC,
        RGN_PROT,
        RGN_NMI,
        RGN_PEND,
        RGN_FIQ,
        RGN_EN,
        RGN_MASK
    } region_e;

    typedef enum logic {
        RSP_IDLE,
        RSP_SEND
    } rsp_state_e;

    // address bits [7:4] select a group, bits [3:2] a slot in the group
    localparam logic [3:0] GRP_CTRL = 4'h0;
    localparam logic [3:0] GRP_PEND = 4'h1;
    localparam logic [3:0] GRP_FIQ  = 4'h2;
    localparam logic [3:0] GRP_EN   = 4'h4;
    localparam logic [3:0] GRP_MASK = 4'h5;

    localparam logic [1:0] SLOT_VEC  = 2'd0;
    localparam logic [1:0] SLOT_PROT = 2'd2;
    localparam logic [1:0] SLOT_NMI  = 2'd3;

    localparam int unsigned VEC_LSB = 2;

endpackage

// File: rtl/bic_addr_dec.sv
module bic_addr_dec
    import bic_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_BANK = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [1:0]        bank
);

    logic hi_zero;

    generate
        if (ADDR_W > 8) begin : g_wide
            assign hi_zero = (addr[ADDR_W-1:8] == '0);
        end else begin : g_narrow
            assign hi_zero = 1'b1;
        end
    endgenerate

    logic bank_ok;
    assign bank    = addr[3:2];
    assign bank_ok = (int'(addr[3:2]) < int'(NUM_BANK));

    always_comb begin
        region = RGN_NONE;
        if (hi_zero && (addr[1:0] == 2'b00)) begin
            case (addr[7:4])
                GRP_CTRL: begin
                    case (addr[3:2])
                        SLOT_VEC:  region = RGN_VEC;
                        SLOT_PROT: region = RGN_PROT;
                        SLOT_NMI:  region = RGN_NMI;
                        default:   region = RGN_NONE;
                    endcase
                end
                GRP_PEND: region = bank_ok ? RGN_PEND : RGN_NONE;
                GRP_FIQ:  region = bank_ok ? RGN_FIQ  : RGN_NONE;
                GRP_EN:   region = bank_ok ? RGN_EN   : RGN_NONE;
                GRP_MASK: region = bank_ok ? RGN_MASK : RGN_NONE;
                default:  region = RGN_NONE;
            endcase
        end
    end

endmodule

// File: rtl/bic_bank.sv
module bic_bank #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         wr_pend,
    input  logic         wr_en,
    input  logic         wr_mask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pend,
    output logic [W-1:0] en,
    output logic [W-1:0] mask
);

    logic [W-1:0] clr;
    assign clr = wr_pend ? wdata : '0;

    // a level still high on the clearing edge keeps its bit set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~clr) | src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= '0;
        end else if (wr_en) begin
            en <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (wr_mask) begin
            mask <= wdata;
        end
    end

endmodule

// File: rtl/bic_prio_enc.sv
module bic_prio_enc #(
    parameter int unsigned N     = 96,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     act,
    output logic [IDX_W-1:0] idx,
    output logic             hit
);

    // scan downward so the lowest set bit wins; bit 0 is never reported
    always_comb begin
        idx = '0;
        hit = 1'b0;
        for (int k = N - 1; k >= 1; k--) begin
            if (act[k]) begin
                idx = IDX_W'(k);
                hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bic_rsp_fsm.sv
module bic_rsp_fsm
    import bic_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd,
    input  logic [W-1:0] rd_word,
    output logic         rvalid,
    output logic [W-1:0] rdata
);

    rsp_state_e   state_q;
    rsp_state_e   state_d;
    logic [W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: state_d = rd ? RSP_SEND : RSP_IDLE;
            RSP_SEND: state_d = rd ? RSP_SEND : RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd) begin
            data_q <= rd_word;
        end
    end

    always_comb begin
        rvalid = 1'b0;
        rdata  = '0;
        unique case (state_q)
            RSP_IDLE: begin
                rvalid = 1'b0;
                rdata  = '0;
            end
            RSP_SEND: begin
                rvalid = 1'b1;
                rdata  = data_q;
            end
        endcase
    end

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import bic_pkg::*;
#(
    parameter int unsigned NUM_BANK = 3,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NMI_W    = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_BANK*DATA_W-1:0]   src_lvl,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic                         bus_rvalid,
    output logic                         irq_out
);

    localparam int unsigned NUM_SRC = NUM_BANK * DATA_W;
    localparam int unsigned IDX_W   = $clog2(NUM_SRC);

    region_e    dec_region;
    logic [1:0] dec_bank;

    bic_addr_dec #(
        .ADDR_W   (ADDR_W),
        .NUM_BANK (NUM_BANK)
    ) u_dec (
        .addr   (bus_addr),
        .region (dec_region),
        .bank   (dec_bank)
    );

    logic [DATA_W-1:0]  pend_b [NUM_BANK];
    logic [DATA_W-1:0]  en_b   [NUM_BANK];
    logic [DATA_W-1:0]  mask_b [NUM_BANK];
    logic [NUM_SRC-1:0] pend_flat;
    logic [NUM_SRC-1:0] act_flat;

    generate
        for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
            logic hit_bank;
            assign hit_bank = bus_wr && (int'(dec_bank) == b);

            bic_bank #(
                .W (DATA_W)
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .src     (src_lvl[b*DATA_W +: DATA_W]),
                .wr_pend (hit_bank && (dec_region == RGN_PEND)),
                .wr_en   (hit_bank && (dec_region == RGN_EN)),
                .wr_mask (hit_bank && (dec_region == RGN_MASK)),
                .wdata   (bus_wdata),
                .pend    (pend_b[b]),
                .en      (en_b[b]),
                .mask    (mask_b[b])
            );

            assign pend_flat[b*DATA_W +: DATA_W] = pend_b[b];
            assign act_flat[b*DATA_W +: DATA_W]  = pend_b[b] & en_b[b] & ~mask_b[b];
        end
    endgenerate

    logic [IDX_W-1:0] vec_idx;
    logic             vec_hit;

    bic_prio_enc #(
        .N     (NUM_SRC),
        .IDX_W (IDX_W)
    ) u_prio (
        .act (act_flat),
        .idx (vec_idx),
        .hit (vec_hit)
    );

    logic [DATA_W-1:0] vec_word;
    assign vec_word = vec_hit ? (DATA_W'(vec_idx) << VEC_LSB) : '0;

    // plain storage registers
    logic             prot_q;
    logic [NMI_W-1:0] nmi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q <= 1'b0;
            nmi_q  <= '0;
        end else if (bus_wr) begin
            if (dec_region == RGN_PROT) begin
                prot_q <= bus_wdata[0];
            end
            if (dec_region == RGN_NMI) begin
                nmi_q <= bus_wdata[NMI_W-1:0];
            end
        end
    end

    // processor interrupt, one register after the active set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_out <= 1'b0;
        end else begin
            irq_out <= |act_flat;
        end
    end

    // read mux
    logic [DATA_W-1:0] rd_word;

    always_comb begin
        rd_word = '0;
        case (dec_region)
            RGN_VEC:  rd_word = vec_word;
            RGN_PROT: rd_word = DATA_W'(prot_q);
            RGN_NMI:  rd_word = DATA_W'(nmi_q);
            RGN_PEND, RGN_FIQ, RGN_EN, RGN_MASK: begin
                for (int b = 0; b < int'(NUM_BANK); b++) begin
                    if (int'(dec_bank) == b) begin
                        case (dec_region)
                            RGN_PEND: rd_word = pend_b[b];
                            RGN_FIQ:  rd_word = pend_b[b] & en_b[b] & mask_b[b];
                            RGN_EN:   rd_word = en_b[b];
                            default:  rd_word = mask_b[b];
                        endcase
                    end
                end
            end
            default:  rd_word = '0;
        endcase
    end

    bic_rsp_fsm #(
        .W (DATA_W)
    ) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (bus_rd),
        .rd_word (rd_word),
        .rvalid  (bus_rvalid),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/banked_irq_ctrl_chk.sv
module banked_irq_ctrl_chk #(
    parameter int unsigned NUM_SRC = 96,
    parameter int unsigned IDX_W   = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_lvl,
    input logic               bus_rd,
    input logic               bus_rvalid,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] pend_flat,
    input logic [NUM_SRC-1:0] act_flat,
    input logic [IDX_W-1:0]   vec_idx
);

    logic [NUM_SRC-1:0] below_vec;
    assign below_vec = ((NUM_SRC'(1) << vec_idx) - NUM_SRC'(1)) & ~NUM_SRC'(1);

    // R1: interrupt line is quiet while reset is held
    assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> !irq_out);

    // R2: every high level is present in the pending set one edge later
    assert_pend_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_flat & $past(src_lvl)) == $past(src_lvl)));

    // R4: a reported vector means the interrupt line rises next cycle
    assert_irq_follows_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_idx != '0) |=> irq_out);

    // R5: the reported source is active
    assert_vec_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_idx != '0) |-> act_flat[vec_idx]);

    // R5: no active source between 1 and the reported one
    assert_vec_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_idx != '0) |-> ((act_flat & below_vec) == '0));

    // R10: a read request is answered the next cycle
    assert_rvalid_after_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R10: no response without a request
    assert_no_spurious_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

endmodule

bind banked_irq_ctrl banked_irq_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_lvl    (src_lvl),
    .bus_rd     (bus_rd),
    .bus_rvalid (bus_rvalid),
    .irq_out    (irq_out),
    .pend_flat  (pend_flat),
    .act_flat   (act_flat),
    .vec_idx    (vec_idx)
);

// File: tb/banked_irq_ctrl_bench.sv
module banked_irq_ctrl_bench;

    localparam int NB = 3;
    localparam int W  = 32;
    localparam int NS = NB * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_lvl = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic          bus_rvalid;
    logic          irq_out;

    always #5 clk = ~clk;

    banked_irq_ctrl u_banked_irq_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_lvl    (src_lvl),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .irq_out    (irq_out)
    );

    // reference state built from the requirements
    logic [W-1:0]  m_pend [NB];
    logic [W-1:0]  m_en   [NB];
    logic [W-1:0]  m_mask [NB];
    logic          m_prot;
    logic [1:0]    m_nmi;
    logic [NS-1:0] src_v;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [NS-1:0] act_m();
        logic [NS-1:0] a;
        for (int b = 0; b < NB; b++) a[b*W +: W] = m_pend[b] & m_en[b] & ~m_mask[b];
        return a;
    endfunction

    function automatic logic [W-1:0] vec_m();
        logic [NS-1:0] a;
        logic [W-1:0]  v;
        a = act_m();
        v = '0;
        for (int k = NS - 1; k >= 1; k--) if (a[k]) v = W'(k) << 2;
        return v;
    endfunction

    function automatic logic [W-1:0] mread(input logic [7:0] a);
        int n;
        n = int'(a[3:2]);
        if (a[1:0] != 2'b00) return '0;
        case (a[7:4])
            4'h0: case (a[3:2])
                      2'd0: return vec_m();
                      2'd2: return W'(m_prot);
                      2'd3: return W'(m_nmi);
                      default: return '0;
                  endcase
            4'h1: return (n < NB) ? m_pend[n] : '0;
            4'h2: return (n < NB) ? (m_pend[n] & m_en[n] & m_mask[n]) : '0;
            4'h4: return (n < NB) ? m_en[n] : '0;
            4'h5: return (n < NB) ? m_mask[n] : '0;
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        if (a[1:0] != 2'b00) return "R9";
        case (a[7:4])
            4'h0: case (a[3:2])
                      2'd0: return "R5";
                      2'd2, 2'd3: return "R8";
                      default: return "R9";
                  endcase
            4'h1: return (a[3:2] < 2'd3) ? "R3" : "R9";
            4'h2: return (a[3:2] < 2'd3) ? "R6" : "R9";
            4'h4, 4'h5: return (a[3:2] < 2'd3) ? "R7" : "R9";
            default: return "R9";
        endcase
    endfunction

    // one clock: drive at the falling edge, update the model at the rising
    // edge, check at the next falling edge
    task automatic cyc(input bit wr, input bit rd, input logic [7:0] a, input logic [W-1:0] wd);
        logic [W-1:0] exp_rd;
        logic         exp_irq;
        logic [W-1:0] clr [NB];
        int           n;
        bus_wr    = wr;
        bus_rd    = rd;
        bus_addr  = a;
        bus_wdata = wd;
        src_lvl   = src_v;
        exp_rd    = mread(a);
        exp_irq   = |act_m();
        @(posedge clk);
        n = int'(a[3:2]);
        for (int b = 0; b < NB; b++) clr[b] = '0;
        if (wr && a[1:0] == 2'b00) begin
            case (a[7:4])
                4'h0: begin
                    if (a[3:2] == 2'd2) m_prot = wd[0];
                    if (a[3:2] == 2'd3) m_nmi  = wd[1:0];
                end
                4'h1: if (n < NB) clr[n] = wd;
                4'h4: if (n < NB) m_en[n] = wd;
                4'h5: if (n < NB) m_mask[n] = wd;
                default: ;
            endcase
        end
        for (int b = 0; b < NB; b++) m_pend[b] = (m_pend[b] & ~clr[b]) | src_v[b*W +: W];
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        chk("R4 irq_out", W'(irq_out), W'(exp_irq));
        chk("R10 rvalid", W'(bus_rvalid), W'(rd));
        if (rd) chk(tag_of(a), bus_rdata, exp_rd);
        else    chk("R10 idle rdata", bus_rdata, '0);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [W-1:0] exp, input string tag);
        logic [W-1:0] got;
        cyc(1'b0, 1'b1, a, '0);
        got = bus_rdata;
        chk(tag, got, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int b = 0; b < NB; b++) begin
            m_pend[b] = '0;
            m_en[b]   = '0;
            m_mask[b] = '0;
        end
        m_prot = 1'b0;
        m_nmi  = '0;
        src_v  = '0;

        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R1 irq in reset", W'(irq_out), '0);
        end
        rst_n = 1'b1;
        rd_chk(8'h00, '0, "R1 vector");
        rd_chk(8'h08, '0, "R1 prot");
        rd_chk(8'h0C, '0, "R1 nmi");
        for (int b = 0; b < NB; b++) begin
            rd_chk(8'(8'h10 + 4 * b), '0, "R1 pend");
            rd_chk(8'(8'h40 + 4 * b), '0, "R1 enable");
            rd_chk(8'(8'h50 + 4 * b), '0, "R1 mask");
        end

        // R2: source 40 lands in bank 1 bit 8
        src_v[40] = 1'b1;
        cyc(1'b0, 1'b0, 8'h00, '0);
        rd_chk(8'h14, 32'h0000_0100, "R2 src40");
        // R3: clear while still high, bit comes back
        cyc(1'b1, 1'b0, 8'h14, 32'h0000_0100);
        rd_chk(8'h14, 32'h0000_0100, "R3 reassert");
        src_v[40] = 1'b0;
        cyc(1'b1, 1'b0, 8'h14, 32'h0000_0100);
        rd_chk(8'h14, 32'h0, "R3 cleared");
        // R3: a zero write keeps a pulsed bit
        src_v[41] = 1'b1;
        cyc(1'b0, 1'b0, 8'h00, '0);
        src_v[41] = 1'b0;
        cyc(1'b1, 1'b0, 8'h14, 32'h0);
        rd_chk(8'h14, 32'h0000_0200, "R3 zero write keeps");
        cyc(1'b1, 1'b0, 8'h14, 32'hFFFF_FFFF);

        // R5: sources 33 and 70, lowest wins, then mask it
        src_v[33] = 1'b1;
        src_v[70] = 1'b1;
        cyc(1'b1, 1'b0, 8'h44, 32'h0000_0002);
        cyc(1'b1, 1'b0, 8'h48, 32'h0000_0040);
        rd_chk(8'h00, 32'h0000_0084, "R5 lowest 33");
        cyc(1'b1, 1'b0, 8'h54, 32'h0000_0002);
        rd_chk(8'h00, 32'h0000_0118, "R5 masked skip to 70");
        // R6: fast view shows the masked enabled source, writes ignored
        rd_chk(8'h24, 32'h0000_0002, "R6 fiq view");
        cyc(1'b1, 1'b0, 8'h24, 32'hFFFF_FFFF);
        rd_chk(8'h24, 32'h0000_0002, "R6 write ignored");
        // R4: disable all, line drops
        cyc(1'b1, 1'b0, 8'h48, 32'h0);
        cyc(1'b0, 1'b0, 8'h00, '0);
        chk("R4 irq low", W'(irq_out), '0);
        src_v[33] = 1'b0;
        src_v[70] = 1'b0;
        cyc(1'b1, 1'b0, 8'h54, 32'h0);
        cyc(1'b1, 1'b0, 8'h14, 32'hFFFF_FFFF);
        cyc(1'b1, 1'b0, 8'h18, 32'hFFFF_FFFF);

        // R5: source 0 drives the line but never the vector
        src_v[0] = 1'b1;
        cyc(1'b1, 1'b0, 8'h40, 32'h0000_0001);
        cyc(1'b0, 1'b0, 8'h00, '0);
        chk("R5 src0 irq", W'(irq_out), 32'h1);
        rd_chk(8'h00, 32'h0, "R5 src0 vector zero");
        src_v[0] = 1'b0;
        cyc(1'b1, 1'b0, 8'h10, 32'hFFFF_FFFF);

        // R7, R8
        cyc(1'b1, 1'b0, 8'h40, 32'hA5A5_5A5A);
        rd_chk(8'h40, 32'hA5A5_5A5A, "R7 enable rw");
        cyc(1'b1, 1'b0, 8'h58, 32'h1234_8765);
        rd_chk(8'h58, 32'h1234_8765, "R7 mask rw");
        cyc(1'b1, 1'b0, 8'h08, 32'hFFFF_FFFF);
        rd_chk(8'h08, 32'h1, "R8 prot");
        cyc(1'b1, 1'b0, 8'h0C, 32'hFFFF_FFFF);
        rd_chk(8'h0C, 32'h3, "R8 nmi");

        // R9: unmapped writes change nothing, reads return zero
        src_v[3] = 1'b1;
        cyc(1'b0, 1'b0, 8'h00, '0);
        src_v[3] = 1'b0;
        cyc(1'b1, 1'b0, 8'h04, 32'hFFFF_FFFF);
        cyc(1'b1, 1'b0, 8'h1C, 32'hFFFF_FFFF);
        cyc(1'b1, 1'b0, 8'h60, 32'hFFFF_FFFF);
        cyc(1'b1, 1'b0, 8'h11, 32'hFFFF_FFFF);
        cyc(1'b1, 1'b0, 8'h41, 32'h0);
        rd_chk(8'h04, 32'h0, "R9 read 0x04");
        rd_chk(8'h1C, 32'h0, "R9 read 0x1C");
        rd_chk(8'h60, 32'h0, "R9 read 0x60");
        rd_chk(8'h10, 32'h0000_0008, "R9 pend untouched");
        rd_chk(8'h40, 32'hA5A5_5A5A, "R9 enable untouched");

        // R10: back-to-back reads
        cyc(1'b0, 1'b1, 8'h40, '0);
        cyc(1'b0, 1'b1, 8'h58, '0);

        // seeded random traffic
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [7:0] a;
            if ($urandom % 3 == 0) begin
                int k;
                k = int'($urandom % NS);
                src_v[k] = ~src_v[k];
            end
            op = int'($urandom % 8);
            a  = 8'(4 * ($urandom % NB));
            case (op)
                0: cyc(1'b1, 1'b0, 8'h40 + a, $urandom & $urandom);
                1: cyc(1'b1, 1'b0, 8'h50 + a, $urandom & $urandom & $urandom);
                2: cyc(1'b1, 1'b0, 8'h10 + a, $urandom);
                3: cyc(1'b0, 1'b1, 8'h10 + a, '0);
                4: cyc(1'b0, 1'b1, 8'h00, '0);
                5: cyc(1'b1, 1'b0, 8'($urandom), $urandom);
                6: cyc(1'b0, 1'b1, 8'($urandom), '0);
                default: cyc(1'b0, 1'b0, 8'h00, '0);
            endcase
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule